// File: doc/BRIEF.md
# Locked Configuration Register Window

This block guards a small bank of configuration registers that share the address window of a drive's task-file I/O port. Normally the window is locked: configuration writes go nowhere and every read returns all ones. A host opens the window by following a fixed knock pattern on the bus: two word-wide reads at the probe offset, then a byte write of the opening key to the key offset. While the window is open, byte accesses reach a read-timing register, a write-timing register, a control register, a miscellaneous register and a read-only version register. A byte write of the closing key to the key offset locks the window again.

The timing registers exist in several copies, called timing sets. An index field in the miscellaneous register picks the copy that the read-timing and write-timing offsets reach. Sets above set A can only be reached after the host has written a special enable value to the control offset while the window was still locked. Every timing set, the control byte and the miscellaneous byte are driven out as ports so the drive-timing logic next to this block can use them. Read data comes back one cycle after the read strobe, with a valid flag.

Top module: `cfg_unlock_port`

## Requirements
- R1: After reset the window is locked (`cfg_open` = 0), every timing set, `cfg_ctrl` and `cfg_misc` are 0x00, and access to set B is disabled.
- R2: The window opens when two consecutive word reads (`acc_wide` = 1) at offset 1 are followed by a byte write of 0x03 at offset 2. `cfg_open` is 1 in the cycle after that write.
- R3: While locked, any access that is not the next expected step restarts the knock pattern. A word read at offset 1 that breaks the pattern counts as its first step, so three word reads followed by the key write do not open the window.
- R4: While open, a byte write of 0x83 at offset 2 locks the window from the next cycle. A byte write of any other value at offset 2 leaves it open.
- R5: While locked, configuration writes leave every configuration output unchanged, and every read returns 0xFF.
- R6: While open, byte writes at offset 0 (read timing), offset 1 (write timing), offset 3 (control) and offset 6 (miscellaneous) update that register. A read at the same offset returns it, with `rd_vld` high in the cycle after the read strobe.
- R7: Offsets 0 and 1 reach set B when bit 0 of the miscellaneous register is 1 and set B access is enabled. In every other case they reach set A. In `rd_tim_sets`/`wr_tim_sets`, set A is bits [7:0] and set B is bits [15:8].
- R8: A byte write at offset 3 while locked enables set B access when its data is 0xC0, and disables it for any other value. Such a write does not change `cfg_ctrl`.
- R9: While open, a read at offset 5 returns the version value 0x00, and reads at offsets 2, 4 and 7 return 0xFF.
- R10: Word writes change no configuration register and never change the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Bus access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = word access, 0 = byte access |
| acc_off | input | 3 | Offset within the I/O window |
| acc_wdata | input | 8 | Write data (low byte of the bus) |
| rd_vld | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 8 | Read data |
| cfg_open | output | 1 | Window is open |
| rd_tim_sets | output | 16 | Read-timing bytes of all sets, set A in the low byte |
| wr_tim_sets | output | 16 | Write-timing bytes of all sets, set A in the low byte |
| cfg_ctrl | output | 8 | Control register |
| cfg_misc | output | 8 | Miscellaneous register |

## Verification
The bench tries broken knock patterns: a byte-wide read in the middle of the pattern, a wrong key value, and one probe read too many. A detector that only counted probe reads, or that never cleared its count, would open on at least one of these. It writes the closing key as a word and writes a wrong key byte while the window is open, to catch a design that decodes the access width or the data loosely and locks at the wrong time. It also checks that set B is reached only after the locked-state enable write, that a later locked write of another value takes that access away, and that the enable write does not change the control register. A wrong gating here would put timing bytes into the set the drive is not using.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   // Register selected by the offset decoder
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RTIM,
      SEL_WTIM,
      SEL_KEY,
      SEL_CTRL,
      SEL_VER,
      SEL_MISC
   } reg_sel_e;

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
   import cfgport_pkg::*;
#(
   parameter int            AW       = 3,
   parameter logic [AW-1:0] OFF_RTIM = AW'(0),
   parameter logic [AW-1:0] OFF_WTIM = AW'(1),
   parameter logic [AW-1:0] OFF_KEY  = AW'(2),
   parameter logic [AW-1:0] OFF_CTRL = AW'(3),
   parameter logic [AW-1:0] OFF_VER  = AW'(5),
   parameter logic [AW-1:0] OFF_MISC = AW'(6)
) (
   input  logic [AW-1:0] off,
   output reg_sel_e      sel
);

   always_comb begin
      if (off == OFF_RTIM)      sel = SEL_RTIM;
      else if (off == OFF_WTIM) sel = SEL_WTIM;
      else if (off == OFF_KEY)  sel = SEL_KEY;
      else if (off == OFF_CTRL) sel = SEL_CTRL;
      else if (off == OFF_VER)  sel = SEL_VER;
      else if (off == OFF_MISC) sel = SEL_MISC;
      else                      sel = SEL_NONE;
   end

endmodule

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
   import cfgport_pkg::*;
#(
   parameter int            AW        = 3,
   parameter int            DW        = 8,
   parameter int            PROBES    = 2,
   parameter logic [AW-1:0] OFF_PROBE = AW'(1),
   parameter logic [DW-1:0] KEY_OPEN  = DW'(8'h03),
   parameter logic [DW-1:0] KEY_CLOSE = DW'(8'h83)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_vld,
   input  logic          acc_we,
   input  logic          acc_wide,
   input  logic [AW-1:0] acc_off,
   input  logic [DW-1:0] acc_wdata,
   input  reg_sel_e      sel,
   output logic          open_o
);

   localparam int CW = $clog2(PROBES + 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(PROBES);
   localparam logic [CW-1:0] CNT_ONE  = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          open_q;
   logic          is_probe;
   logic          is_key_byte;
   logic          open_hit;
   logic          close_hit;

   assign is_probe    = acc_vld && !acc_we && acc_wide && (acc_off == OFF_PROBE);
   assign is_key_byte = acc_vld && acc_we && !acc_wide && (sel == SEL_KEY);
   assign open_hit    = !open_q && is_key_byte && (acc_wdata == KEY_OPEN) && (cnt_q == CNT_FULL);
   assign close_hit   = open_q && is_key_byte && (acc_wdata == KEY_CLOSE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (open_hit) begin
         open_q <= 1'b1;
      end else if (close_hit) begin
         open_q <= 1'b0;
      end
   end

   // Probe counter: a probe past the full count restarts at one step
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (open_q || open_hit) begin
         cnt_q <= '0;
      end else if (is_probe) begin
         cnt_q <= (cnt_q == CNT_FULL) ? CNT_ONE : cnt_q + CNT_ONE;
      end else if (acc_vld) begin
         cnt_q <= '0;
      end
   end

   assign open_o = open_q;

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
   import cfgport_pkg::*;
#(
   parameter int            DW       = 8,
   parameter int            NSETS    = 2,
   parameter int            IDX_LSB  = 0,
   parameter logic [DW-1:0] BANK_KEY = DW'(8'hC0)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                lk_ctrl_wr,
   input  reg_sel_e            sel,
   input  logic [DW-1:0]       wdata,
   output logic [NSETS*DW-1:0] rtim_flat,
   output logic [NSETS*DW-1:0] wtim_flat,
   output logic [DW-1:0]       rtim_cur,
   output logic [DW-1:0]       wtim_cur,
   output logic [DW-1:0]       ctrl_o,
   output logic [DW-1:0]       misc_o
);

   localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1;

   logic [DW-1:0]    ctrl_q;
   logic [DW-1:0]    misc_q;
   logic             ext_en_q;
   logic [SEL_W-1:0] idx;
   logic [SEL_W-1:0] cur;

   assign idx = misc_q[IDX_LSB +: SEL_W];

   always_comb begin
      if ((idx != '0) && ext_en_q && (int'(idx) < NSETS)) cur = idx;
      else                                                cur = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         misc_q   <= '0;
         ext_en_q <= 1'b0;
      end else begin
         if (wr_en && (sel == SEL_CTRL)) ctrl_q <= wdata;
         if (wr_en && (sel == SEL_MISC)) misc_q <= wdata;
         if (lk_ctrl_wr)                 ext_en_q <= (wdata == BANK_KEY);
      end
   end

   for (genvar g = 0; g < NSETS; g++) begin : g_set
      logic [DW-1:0] rt_q;
      logic [DW-1:0] wt_q;
      logic          hit;

      assign hit = wr_en && (cur == SEL_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rt_q <= '0;
            wt_q <= '0;
         end else begin
            if (hit && (sel == SEL_RTIM)) rt_q <= wdata;
            if (hit && (sel == SEL_WTIM)) wt_q <= wdata;
         end
      end

      assign rtim_flat[g*DW +: DW] = rt_q;
      assign wtim_flat[g*DW +: DW] = wt_q;
   end

   assign rtim_cur = rtim_flat[cur*DW +: DW];
   assign wtim_cur = wtim_flat[cur*DW +: DW];
   assign ctrl_o   = ctrl_q;
   assign misc_o   = misc_q;

endmodule

// File: rtl/cfg_rdmux.sv
module cfg_rdmux
   import cfgport_pkg::*;
#(
   parameter int            DW      = 8,
   parameter logic [DW-1:0] VERSION = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic          open_i,
   input  reg_sel_e      sel,
   input  logic [DW-1:0] rtim_cur,
   input  logic [DW-1:0] wtim_cur,
   input  logic [DW-1:0] ctrl_i,
   input  logic [DW-1:0] misc_i,
   output logic          rd_vld,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] rd_nxt;

   always_comb begin
      rd_nxt = '1;
      if (open_i) begin
         case (sel)
            SEL_RTIM: rd_nxt = rtim_cur;
            SEL_WTIM: rd_nxt = wtim_cur;
            SEL_CTRL: rd_nxt = ctrl_i;
            SEL_MISC: rd_nxt = misc_i;
            SEL_VER:  rd_nxt = VERSION;
            default:  rd_nxt = '1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_vld  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_vld <= rd_req;
         if (rd_req) rd_data <= rd_nxt;
      end
   end

endmodule

// File: rtl/cfg_unlock_port.sv
module cfg_unlock_port
   import cfgport_pkg::*;
#(
   parameter int            AW        = 3,
   parameter int            DW        = 8,
   parameter int            NSETS     = 2,
   parameter int            PROBES    = 2,
   parameter int            IDX_LSB   = 0,
   parameter logic [AW-1:0] OFF_RTIM  = AW'(0),
   parameter logic [AW-1:0] OFF_WTIM  = AW'(1),
   parameter logic [AW-1:0] OFF_KEY   = AW'(2),
   parameter logic [AW-1:0] OFF_CTRL  = AW'(3),
   parameter logic [AW-1:0] OFF_VER   = AW'(5),
   parameter logic [AW-1:0] OFF_MISC  = AW'(6),
   parameter logic [AW-1:0] OFF_PROBE = AW'(1),
   parameter logic [DW-1:0] KEY_OPEN  = DW'(8'h03),
   parameter logic [DW-1:0] KEY_CLOSE = DW'(8'h83),
   parameter logic [DW-1:0] BANK_KEY  = DW'(8'hC0),
   parameter logic [DW-1:0] VERSION   = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_vld,
   input  logic                acc_we,
   input  logic                acc_wide,
   input  logic [AW-1:0]       acc_off,
   input  logic [DW-1:0]       acc_wdata,
   output logic                rd_vld,
   output logic [DW-1:0]       rd_data,
   output logic                cfg_open,
   output logic [NSETS*DW-1:0] rd_tim_sets,
   output logic [NSETS*DW-1:0] wr_tim_sets,
   output logic [DW-1:0]       cfg_ctrl,
   output logic [DW-1:0]       cfg_misc
);

   localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1;

   // Elaboration-time parameter checks
   if (NSETS < 2) begin : g_chk_nsets
      $error("NSETS must be at least 2");
   end
   if (PROBES < 1) begin : g_chk_probes
      $error("PROBES must be at least 1");
   end
   if (IDX_LSB + SEL_W > DW) begin : g_chk_idx
      $error("set index field does not fit in the miscellaneous register");
   end
   if ((OFF_KEY == OFF_RTIM) || (OFF_KEY == OFF_WTIM) || (OFF_KEY == OFF_CTRL) ||
       (OFF_KEY == OFF_MISC) || (OFF_KEY == OFF_VER)) begin : g_chk_key
      $error("key offset collides with a register offset");
   end
   if ((OFF_RTIM == OFF_WTIM) || (OFF_CTRL == OFF_MISC) || (OFF_VER == OFF_MISC) ||
       (OFF_VER == OFF_CTRL)) begin : g_chk_off
      $error("register offsets must be distinct");
   end
   if (KEY_OPEN == KEY_CLOSE) begin : g_chk_keys
      $error("opening and closing keys must differ");
   end

   reg_sel_e      sel;
   logic          open_w;
   logic          byte_wr;
   logic          wr_en;
   logic          lk_ctrl_wr;
   logic          rd_req;
   logic [DW-1:0] rtim_cur;
   logic [DW-1:0] wtim_cur;

   assign byte_wr    = acc_vld && acc_we && !acc_wide;
   assign wr_en      = byte_wr && open_w;
   assign lk_ctrl_wr = byte_wr && !open_w && (sel == SEL_CTRL);
   assign rd_req     = acc_vld && !acc_we;

   cfg_decode #(
      .AW(AW), .OFF_RTIM(OFF_RTIM), .OFF_WTIM(OFF_WTIM), .OFF_KEY(OFF_KEY),
      .OFF_CTRL(OFF_CTRL), .OFF_VER(OFF_VER), .OFF_MISC(OFF_MISC)
   ) u_dec (
      .off (acc_off),
      .sel (sel)
   );

   cfg_unlock_seq #(
      .AW(AW), .DW(DW), .PROBES(PROBES), .OFF_PROBE(OFF_PROBE),
      .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_vld   (acc_vld),
      .acc_we    (acc_we),
      .acc_wide  (acc_wide),
      .acc_off   (acc_off),
      .acc_wdata (acc_wdata),
      .sel       (sel),
      .open_o    (open_w)
   );

   cfg_regbank #(
      .DW(DW), .NSETS(NSETS), .IDX_LSB(IDX_LSB), .BANK_KEY(BANK_KEY)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .lk_ctrl_wr (lk_ctrl_wr),
      .sel        (sel),
      .wdata      (acc_wdata),
      .rtim_flat  (rd_tim_sets),
      .wtim_flat  (wr_tim_sets),
      .rtim_cur   (rtim_cur),
      .wtim_cur   (wtim_cur),
      .ctrl_o     (cfg_ctrl),
      .misc_o     (cfg_misc)
   );

   cfg_rdmux #(
      .DW(DW), .VERSION(VERSION)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .open_i   (open_w),
      .sel      (sel),
      .rtim_cur (rtim_cur),
      .wtim_cur (wtim_cur),
      .ctrl_i   (cfg_ctrl),
      .misc_i   (cfg_misc),
      .rd_vld   (rd_vld),
      .rd_data  (rd_data)
   );

   assign cfg_open = open_w;

endmodule

// File: rtl/cfg_unlock_port_chk.sv
module cfg_unlock_port_chk #(
   parameter int            AW        = 3,
   parameter int            DW        = 8,
   parameter int            NSETS     = 2,
   parameter logic [AW-1:0] OFF_KEY   = AW'(2),
   parameter logic [AW-1:0] OFF_VER   = AW'(5),
   parameter logic [DW-1:0] KEY_OPEN  = DW'(8'h03),
   parameter logic [DW-1:0] KEY_CLOSE = DW'(8'h83),
   parameter logic [DW-1:0] VERSION   = '0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                acc_vld,
   input logic                acc_we,
   input logic                acc_wide,
   input logic [AW-1:0]       acc_off,
   input logic [DW-1:0]       acc_wdata,
   input logic                rd_vld,
   input logic [DW-1:0]       rd_data,
   input logic                cfg_open,
   input logic [NSETS*DW-1:0] rd_tim_sets,
   input logic [NSETS*DW-1:0] wr_tim_sets,
   input logic [DW-1:0]       cfg_ctrl,
   input logic [DW-1:0]       cfg_misc
);

   logic key_byte;
   assign key_byte = acc_vld && acc_we && !acc_wide && (acc_off == OFF_KEY);

   assert_open_only_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && !(key_byte && (acc_wdata == KEY_OPEN))) |=> !cfg_open);

   assert_close_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && key_byte && (acc_wdata == KEY_CLOSE)) |=> !cfg_open);

   assert_locked_read_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !acc_we && !cfg_open) |=> (rd_vld && (rd_data == '1)));

   assert_locked_cfg_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> ($stable(rd_tim_sets) && $stable(wr_tim_sets) && $stable(cfg_ctrl) &&
                     $stable(cfg_misc)));

   assert_rd_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !acc_we) |=> rd_vld);

   assert_no_spurious_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_vld && !acc_we) |=> !rd_vld);

   assert_version_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && acc_vld && !acc_we && (acc_off == OFF_VER)) |=> (rd_data == VERSION));

   assert_word_write_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_we && acc_wide) |=> ($stable(cfg_open) && $stable(rd_tim_sets) &&
                                           $stable(wr_tim_sets) && $stable(cfg_ctrl) &&
                                           $stable(cfg_misc)));

endmodule

bind cfg_unlock_port cfg_unlock_port_chk #(
   .AW(AW), .DW(DW), .NSETS(NSETS), .OFF_KEY(OFF_KEY), .OFF_VER(OFF_VER),
   .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE), .VERSION(VERSION)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_vld     (acc_vld),
   .acc_we      (acc_we),
   .acc_wide    (acc_wide),
   .acc_off     (acc_off),
   .acc_wdata   (acc_wdata),
   .rd_vld      (rd_vld),
   .rd_data     (rd_data),
   .cfg_open    (cfg_open),
   .rd_tim_sets (rd_tim_sets),
   .wr_tim_sets (wr_tim_sets),
   .cfg_ctrl    (cfg_ctrl),
   .cfg_misc    (cfg_misc)
);

// File: tb/sim_cfg_unlock_port.sv
`timescale 1ns/1ps
module sim_cfg_unlock_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_vld = 1'b0;
   logic        acc_we = 1'b0;
   logic        acc_wide = 1'b0;
   logic [2:0]  acc_off = '0;
   logic [7:0]  acc_wdata = '0;
   logic        rd_vld;
   logic [7:0]  rd_data;
   logic        cfg_open;
   logic [15:0] rd_tim_sets;
   logic [15:0] wr_tim_sets;
   logic [7:0]  cfg_ctrl;
   logic [7:0]  cfg_misc;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   cfg_unlock_port u0 (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_we(acc_we), .acc_wide(acc_wide),
      .acc_off(acc_off), .acc_wdata(acc_wdata), .rd_vld(rd_vld), .rd_data(rd_data),
      .cfg_open(cfg_open), .rd_tim_sets(rd_tim_sets), .wr_tim_sets(wr_tim_sets),
      .cfg_ctrl(cfg_ctrl), .cfg_misc(cfg_misc)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic acc(input bit we, input bit wide, input logic [2:0] off, input logic [7:0] d);
      @(negedge clk);
      acc_vld = 1'b1; acc_we = we; acc_wide = wide; acc_off = off; acc_wdata = d;
      @(posedge clk);
      #1 acc_vld = 1'b0;
   endtask

   task automatic wrb(input logic [2:0] off, input logic [7:0] d);
      acc(1'b1, 1'b0, off, d);
   endtask

   // Driver side of the scoreboard: push the expected byte, then issue the read
   task automatic rd(input logic [2:0] off, input bit wide, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      acc(1'b0, wide, off, 8'h00);
   endtask

   task automatic knock();
      rd(3'd1, 1'b1, 8'hFF, "R5 probe read");
      rd(3'd1, 1'b1, 8'hFF, "R5 probe read");
      wrb(3'd2, 8'h03);
   endtask

   // Monitor: pop and compare each read result
   always @(negedge clk) begin
      if (rst_n && rd_vld) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R6 unexpected rd_vld: actual data %h expected no read", rd_data);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {24'd0, rd_data}, {24'd0, e});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1 open", {31'd0, cfg_open}, 0);
      chk("R1 rtim", {16'd0, rd_tim_sets}, 0);
      chk("R1 wtim", {16'd0, wr_tim_sets}, 0);
      chk("R1 ctrl", {24'd0, cfg_ctrl}, 0);
      chk("R1 misc", {24'd0, cfg_misc}, 0);

      // R5 locked reads and writes
      rd(3'd0, 1'b0, 8'hFF, "R5 locked read off0");
      rd(3'd5, 1'b0, 8'hFF, "R5 locked read off5");
      wrb(3'd0, 8'h55);
      chk("R5 locked write ignored", {16'd0, rd_tim_sets}, 0);

      // R2 unlock
      knock();
      chk("R2 open after knock", {31'd0, cfg_open}, 1);

      // R9 version and unused offsets
      rd(3'd5, 1'b0, 8'h00, "R9 version");
      rd(3'd4, 1'b0, 8'hFF, "R9 off4");
      rd(3'd2, 1'b0, 8'hFF, "R9 off2");
      rd(3'd7, 1'b0, 8'hFF, "R9 off7");

      // R6 register writes and readback
      wrb(3'd0, 8'h12);
      wrb(3'd1, 8'h34);
      chk("R6 rtim A", {24'd0, rd_tim_sets[7:0]}, 32'h12);
      chk("R6 wtim A", {24'd0, wr_tim_sets[7:0]}, 32'h34);
      rd(3'd0, 1'b0, 8'h12, "R6 read rtim");
      rd(3'd1, 1'b0, 8'h34, "R6 read wtim");

      // R7 index set but set B access not enabled
      wrb(3'd6, 8'h01);
      chk("R6 misc", {24'd0, cfg_misc}, 32'h01);
      wrb(3'd0, 8'h77);
      chk("R7 no B without enable: A", {24'd0, rd_tim_sets[7:0]}, 32'h77);
      chk("R7 no B without enable: B", {24'd0, rd_tim_sets[15:8]}, 32'h00);

      wrb(3'd3, 8'h85);
      chk("R6 ctrl", {24'd0, cfg_ctrl}, 32'h85);
      rd(3'd3, 1'b0, 8'h85, "R6 read ctrl");
      rd(3'd6, 1'b0, 8'h01, "R6 read misc");

      // R10 word writes inert
      acc(1'b1, 1'b1, 3'd0, 8'hAA);
      chk("R10 word write rtim", {24'd0, rd_tim_sets[7:0]}, 32'h77);
      acc(1'b1, 1'b1, 3'd2, 8'h83);
      chk("R10 word close key", {31'd0, cfg_open}, 1);

      // R4 wrong close value then close
      wrb(3'd2, 8'h55);
      chk("R4 wrong close value", {31'd0, cfg_open}, 1);
      wrb(3'd2, 8'h83);
      chk("R4 closed", {31'd0, cfg_open}, 0);
      rd(3'd0, 1'b0, 8'hFF, "R5 read after close");

      // R8 enable set B while locked
      wrb(3'd3, 8'hC0);
      chk("R8 ctrl unchanged", {24'd0, cfg_ctrl}, 32'h85);
      knock();
      chk("R2 reopen", {31'd0, cfg_open}, 1);
      wrb(3'd0, 8'h9A);
      chk("R7 set B written", {24'd0, rd_tim_sets[15:8]}, 32'h9A);
      chk("R7 set A kept", {24'd0, rd_tim_sets[7:0]}, 32'h77);
      rd(3'd0, 1'b0, 8'h9A, "R7 read set B");
      wrb(3'd6, 8'h00);
      rd(3'd0, 1'b0, 8'h77, "R7 read set A");
      wrb(3'd2, 8'h83);

      // R3 broken sequences
      rd(3'd1, 1'b1, 8'hFF, "R5 probe");
      rd(3'd1, 1'b0, 8'hFF, "R5 byte read");
      rd(3'd1, 1'b1, 8'hFF, "R5 probe");
      wrb(3'd2, 8'h03);
      chk("R3 byte read breaks pattern", {31'd0, cfg_open}, 0);
      rd(3'd1, 1'b1, 8'hFF, "R5 probe");
      rd(3'd1, 1'b1, 8'hFF, "R5 probe");
      wrb(3'd2, 8'h04);
      chk("R3 wrong key", {31'd0, cfg_open}, 0);
      wrb(3'd2, 8'h03);
      chk("R3 key without probes", {31'd0, cfg_open}, 0);
      rd(3'd1, 1'b1, 8'hFF, "R5 probe");
      rd(3'd1, 1'b1, 8'hFF, "R5 probe");
      rd(3'd1, 1'b1, 8'hFF, "R5 probe");
      wrb(3'd2, 8'h03);
      chk("R3 three probes", {31'd0, cfg_open}, 0);
      knock();
      chk("R2 open after clean knock", {31'd0, cfg_open}, 1);
      wrb(3'd2, 8'h83);

      // R8 other value disables set B
      wrb(3'd3, 8'h11);
      chk("R8 ctrl unchanged again", {24'd0, cfg_ctrl}, 32'h85);
      knock();
      wrb(3'd6, 8'h01);
      wrb(3'd0, 8'h3C);
      chk("R8 disabled: A written", {24'd0, rd_tim_sets[7:0]}, 32'h3C);
      chk("R8 disabled: B kept", {24'd0, rd_tim_sets[15:8]}, 32'h9A);

      repeat (3) @(posedge clk);
      chk("R6 all reads returned", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule